// File: doc/BRIEF.md
# Programmable Systematic Block Encoder

This block turns each 4-bit message into a 7-bit systematic codeword. The message passes through unchanged in the upper four codeword bits, and three parity bits follow it. Each parity bit is the modulo-2 sum of the message bits selected by one column of a 4×3 parity submatrix. That submatrix is not fixed wiring. It is a 12-bit coefficient register that can be rewritten at run time, so the same logic can encode any 4×3 parity pattern.

Messages enter on a valid/ready stream. Each codeword sits in a single output register until the downstream side takes it. The input stream is ready whenever that register is empty or is being emptied in the same cycle, so back-to-back messages are encoded at one codeword per clock with one cycle of latency. A coefficient write applies to messages accepted after the write. It never changes a codeword that has already been produced.

Top module: `sys_block_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is cleared and the coefficient register returns to its default value 12'h7E8.
- R2: For a message accepted on `in_data`, the next codeword carries that message unchanged in `out_data[6:3]`, with `in_data[3]` (m1) at `out_data[6]`.
- R3: Parity bit p(j+1), for j = 0..2, is the XOR over i of `in_data[i] & coef[4*j+i]`. It appears at `out_data[2-j]`, so p1 is at bit 2, p2 at bit 1 and p3 at bit 0.
- R4: With the default coefficients, message 4'b1011 encodes to 7'b1011100.
- R5: When `cfg_we` is high at an edge, `cfg_data` is loaded at that edge. A message accepted at that same edge is encoded with the old coefficients. Later messages use the new ones. A codeword already waiting at the output is not changed.
- R6: `in_ready` equals `!out_valid || out_ready`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change at the next edge.
- R8: A message accepted at an edge makes `out_valid` high after that edge. With `in_valid` and `out_ready` both held high, one codeword leaves every clock.
- R9: A message offered while `in_ready` is low is not accepted, and no codeword is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_data | input | 12 | New coefficient word; nibble j is parity column j, and bit i of the nibble weights message bit i |
| in_valid | input | 1 | Message present |
| in_data | input | 4 | Message bits, m1 in bit 3 |
| in_ready | output | 1 | Message is taken at this edge if `in_valid` is high |
| out_valid | output | 1 | Codeword present |
| out_data | output | 7 | Codeword: message in bits 6:3, then p1, p2 and p3 |
| out_ready | input | 1 | Downstream takes the codeword at this edge |

## Verification
All 16 messages are encoded under the default coefficients and under several coefficient words: all-zero, all-one, and random words drawn from a seeded generator. The all-zero word isolates the systematic part, the all-one word gives plain column parity, and the random words show whether each column and bit position is mapped correctly. Random stalls on the output and random gaps on the input exercise holding a codeword, refusing messages and dropping nothing. A directed sequence writes the coefficients while a codeword is stalled and again in the same cycle as an accept, to show exactly which messages see the new word. A continuous stream checks the one-per-clock rate.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  // Shape of the default code
  localparam int unsigned MSG_BITS_DEF = 4;
  localparam int unsigned PAR_BITS_DEF = 3;

  // Reset coefficients: column p1 = 4'b1000, p2 = 4'b1110, p3 = 4'b0111
  localparam logic [11:0] COEF_RESET_DEF = 12'h7E8;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_e;

endpackage

// File: rtl/sbe_coef_reg.sv
module sbe_coef_reg #(
  parameter int unsigned MSG_BITS = 4,
  parameter int unsigned PAR_BITS = 3,
  parameter int unsigned COEF_BITS = MSG_BITS * PAR_BITS,
  parameter logic [COEF_BITS-1:0] COEF_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [COEF_BITS-1:0] wr_word,
  output logic [COEF_BITS-1:0] coef
);

  always_ff @(posedge clk) begin
    if (rst) begin
      coef <= COEF_RESET;
    end else if (wr_en) begin
      coef <= wr_word;
    end
  end

  // R5: a write lands at its own edge
  p_cfg_load_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> coef == $past(wr_word));

  // R5: without a write the coefficients do not move
  p_cfg_keep_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(coef));

endmodule

// File: rtl/sbe_parity_core.sv
module sbe_parity_core #(
  parameter int unsigned MSG_BITS = 4,
  parameter int unsigned PAR_BITS = 3,
  parameter int unsigned COEF_BITS = MSG_BITS * PAR_BITS
) (
  input  logic [MSG_BITS-1:0]  msg,
  input  logic [COEF_BITS-1:0] coef,
  output logic [PAR_BITS-1:0]  parity
);

  // Column j produces parity bit j+1, which is placed MSB-first
  for (genvar j = 0; j < PAR_BITS; j++) begin : g_col
    logic [MSG_BITS-1:0] taps;
    assign taps = msg & coef[j*MSG_BITS +: MSG_BITS];
    assign parity[PAR_BITS-1-j] = ^taps;
  end

endmodule

// File: rtl/sbe_out_slot.sv
module sbe_out_slot #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             take,
  output logic             slot_free,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  import sbe_pkg::*;

  slot_state_e state;
  logic        rst_d;

  assign valid     = (state == SLOT_FULL);
  assign slot_free = (state == SLOT_EMPTY) || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SLOT_EMPTY;
    end else if (load) begin
      state <= SLOT_FULL;
    end else if (take) begin
      state <= SLOT_EMPTY;
    end
  end

  // The data register has no reset
  always_ff @(posedge clk) begin
    if (load) begin
      data <= load_data;
    end
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
  end

  // R1: the cycle after reset shows an empty slot
  always_ff @(posedge clk) begin
    if (rst_d) begin
      p_reset_clear_r1: assert (!valid);
    end
  end

  // R7: a stalled codeword stays put
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    valid && !take |=> valid && $stable(data));

  // R8: a load always shows up at the next edge
  p_load_visible_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> valid);

  // R8: a drain with no refill empties the slot
  p_drain_empty_r8: assert property (@(posedge clk) disable iff (rst)
    valid && take && !load |=> !valid);

  // R9: nothing is loaded over a stalled codeword
  p_no_overwrite_r9: assert property (@(posedge clk) disable iff (rst)
    valid && !take |-> !load);

endmodule

// File: rtl/sys_block_encoder.sv
module sys_block_encoder #(
  parameter int unsigned MSG_BITS = sbe_pkg::MSG_BITS_DEF,
  parameter int unsigned PAR_BITS = sbe_pkg::PAR_BITS_DEF,
  parameter logic [MSG_BITS*PAR_BITS-1:0] COEF_RESET = sbe_pkg::COEF_RESET_DEF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [MSG_BITS*PAR_BITS-1:0]   cfg_data,
  input  logic                           in_valid,
  input  logic [MSG_BITS-1:0]            in_data,
  output logic                           in_ready,
  output logic                           out_valid,
  output logic [MSG_BITS+PAR_BITS-1:0]   out_data,
  input  logic                           out_ready
);

  localparam int unsigned COEF_BITS = MSG_BITS * PAR_BITS;
  localparam int unsigned CW_BITS   = MSG_BITS + PAR_BITS;

  logic [COEF_BITS-1:0] coef;
  logic [PAR_BITS-1:0]  parity;
  logic [CW_BITS-1:0]   codeword;
  logic                 accept;
  logic                 slot_free;

  sbe_coef_reg #(
    .MSG_BITS  (MSG_BITS),
    .PAR_BITS  (PAR_BITS),
    .COEF_BITS (COEF_BITS),
    .COEF_RESET(COEF_RESET)
  ) u_coef (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_word(cfg_data),
    .coef   (coef)
  );

  sbe_parity_core #(
    .MSG_BITS (MSG_BITS),
    .PAR_BITS (PAR_BITS),
    .COEF_BITS(COEF_BITS)
  ) u_par (
    .msg   (in_data),
    .coef  (coef),
    .parity(parity)
  );

  assign in_ready = slot_free;
  assign accept   = in_valid && slot_free;
  assign codeword = {in_data, parity};

  sbe_out_slot #(
    .WIDTH(CW_BITS)
  ) u_slot (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_data(codeword),
    .take     (out_ready),
    .slot_free(slot_free),
    .valid    (out_valid),
    .data     (out_data)
  );

  // R2: the message reaches the upper codeword bits unchanged
  p_systematic_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_data[CW_BITS-1 -: MSG_BITS] == $past(in_data));

  // R6: the input is open only when the slot can take a message
  p_ready_rule_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: tb/sys_block_encoder_tb_top.sv
module sys_block_encoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] DEF_COEF = 12'h7E8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [11:0] cfg_data;
  logic        in_valid;
  logic [3:0]  in_data;
  logic        in_ready;
  logic        out_valid;
  logic [6:0]  out_data;
  logic        out_ready;

  int tests_run = 0;
  int tests_failed = 0;

  logic [6:0]  exp_q[$];
  logic [11:0] coef_model;
  logic        stall_prev;
  logic [6:0]  held_word;
  logic        last_acc;
  logic [6:0]  last_out;
  int          xfers;
  string       cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_block_encoder dut_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ready(out_ready)
  );

  // Expected codeword: message on top, then p1 p2 p3 (R2, R3)
  function automatic logic [6:0] ref_cw(input logic [3:0] m, input logic [11:0] c);
    logic [2:0] p;
    for (int j = 0; j < 3; j++) begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < 4; i++) acc = acc ^ (m[i] & c[4*j+i]);
      p[2-j] = acc;
    end
    return {m, p};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, check at the falling edge, track expectations
  task automatic step(input logic v, input logic [3:0] d, input logic ordy,
                      input logic we, input logic [11:0] cd);
    in_valid = v; in_data = d; out_ready = ordy; cfg_we = we; cfg_data = cd;
    @(negedge clk);
    if (stall_prev)
      check(out_valid && out_data == held_word, "R7", {4'h0, out_valid, out_data}, {5'h1, held_word});
    check(in_ready == (!out_valid || out_ready), "R6", {11'h0, in_ready}, {11'h0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      xfers++;
      last_out = out_data;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", {5'h0, out_data}, 12'h0);
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check(out_data == e, {"R2 R3 ", cur_tag}, {5'h0, out_data}, {5'h0, e});
      end
    end
    last_acc = v && in_ready;
    if (last_acc) exp_q.push_back(ref_cw(d, coef_model));
    if (we) coef_model = cd;
    stall_prev = out_valid && !out_ready;
    held_word  = out_data;
    @(posedge clk); #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 8 && (exp_q.size() != 0 || out_valid); k++) step(1'b0, 4'h0, 1'b1, 1'b0, 12'h0);
    check(exp_q.size() == 0 && !out_valid, "R9", {11'h0, out_valid}, 12'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cfg_we = 1'b0; cfg_data = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    stall_prev = 1'b0; held_word = '0; xfers = 0; cur_tag = "R1"; coef_model = DEF_COEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1", {11'h0, out_valid}, 12'h0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R4: default coefficients after reset
    cur_tag = "R4";
    step(1'b1, 4'b1011, 1'b1, 1'b0, 12'h0);
    step(1'b0, 4'b0000, 1'b1, 1'b0, 12'h0);
    check(last_out == 7'b1011100, "R4", {5'h0, last_out}, 12'h05C);

    // R8: continuous stream of all 16 messages
    cur_tag = "R8";
    xfers = 0;
    for (int m = 0; m < 16; m++) step(1'b1, 4'(m), 1'b1, 1'b0, 12'h0);
    step(1'b0, 4'h0, 1'b1, 1'b0, 12'h0);
    check(xfers == 16, "R8", 12'(xfers), 12'd16);

    // R5: write while a codeword is stalled, then in the cycle of an accept
    cur_tag = "R5";
    step(1'b1, 4'hA, 1'b0, 1'b0, 12'h0);
    step(1'b1, 4'h5, 1'b0, 1'b1, 12'hFFF);
    check(!last_acc, "R9", {11'h0, last_acc}, 12'h0);
    step(1'b1, 4'h5, 1'b1, 1'b1, 12'h123);
    step(1'b1, 4'h6, 1'b1, 1'b0, 12'h0);
    drain();

    // Coefficient sets: zero, all-one, random, with random stalls and gaps
    for (int s = 0; s < 6; s++) begin
      logic [11:0] cs;
      cs = (s == 0) ? 12'h000 : (s == 1) ? 12'hFFF : 12'($urandom);
      cur_tag = "R3";
      step(1'b0, 4'h0, 1'b1, 1'b1, cs);
      for (int m = 0; m < 16; m++) begin
        int tries;
        tries = 0;
        do begin
          logic v;
          v = ($urandom % 4) != 0;
          step(v, 4'(m), ($urandom % 10) < 7, 1'b0, 12'h0);
          tries++;
        end while (!last_acc && tries < 50);
      end
      drain();
    end

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule